// File: doc/BRIEF.md
# DDR2 Mode Register Command Issuer

This controller-side block writes one of the four DDR2 mode registers. A single request carries the burst length in beats, the burst ordering, the CAS latency in clocks, the write-recovery time and the clock period in picoseconds, the power-down exit choice and the register to target. The block checks the request, forms the bank and address word, and waits until the memory reports every bank precharged and CKE high. It then drives the four command strobes low for exactly one clock. After that it refuses new work until the mode-register cycle time has passed.

The write-recovery field is derived in hardware as the rounded-up ratio of the recovery time to the clock period, so software never has to do the division. Requests whose burst length, CAS latency or recovery time cannot be encoded are refused with a one-cycle error pulse instead of being sent.

Top module: `ddr2_mrs_issuer`

## Requirements
- R1: When idle and after reset, cs_n, ras_n, cas_n and we_n are all high. A command is all four low together for exactly one clock.
- R2: A command is driven only in the cycle after a clock edge at which all_precharged and cke_high were both high. An accepted request whose preconditions are missing waits, for any number of cycles, and is then issued.
- R3: For target 00 the address word holds the burst code on addr[2:0] (010 for 4 beats, 011 for 8). It holds the ordering on addr[3] (0 sequential, 1 interleaved) and the CAS latency value on addr[6:4]. addr[8:7] is 00 and the slow-exit bit is on addr[12].
- R4: ba carries the target select: 00 main, 01 extended 1, 10 extended 2, 11 extended 3. For targets 01 to 11 the address is all zero and the burst, latency and recovery inputs are not checked.
- R5: The write-recovery count is ceil(twr_ps / tck_ps). A count of 1 or less is raised to 2, and addr[11:9] carries count minus 1 (001 = 2 cycles up to 111 = 8).
- R6: busy goes high at the edge that accepts a request. It returns low TMRD clock edges after the edge that issues the command.
- R7: Two commands are always at least TMRD+1 clocks apart.
- R8: For target 00, the request is refused when the burst length is not 4 or 8, the CAS latency is outside CL_MIN..CL_MAX, the count exceeds 8, or tck_ps is zero. On refusal err is high for the one cycle after the request, no command follows and busy stays low.
- R9: A request raised while busy is high is ignored and causes no further command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req | input | 1 | Request to write a mode register, sampled while not busy |
| cfg_bl | input | 4 | Burst length in beats |
| cfg_interleave | input | 1 | Burst ordering, 1 = interleaved |
| cfg_cl | input | 3 | CAS latency in clocks |
| cfg_twr_ps | input | PS_W | Write-recovery time in picoseconds |
| cfg_tck_ps | input | PS_W | Clock period in picoseconds |
| cfg_slow_exit | input | 1 | Active power-down exit, 1 = slow |
| cfg_target | input | 2 | Register select driven onto ba |
| all_precharged | input | 1 | Every bank is precharged |
| cke_high | input | 1 | CKE is already high |
| cs_n | output | 1 | Chip select strobe |
| ras_n | output | 1 | Row strobe |
| cas_n | output | 1 | Column strobe |
| we_n | output | 1 | Write enable strobe |
| ba | output | 2 | Bank address, carries the target |
| addr | output | 13 | Register contents |
| busy | output | 1 | Request accepted and hold-off not yet over |
| err | output | 1 | One-cycle pulse for a refused request |

## Verification
The bench builds the block with TMRD = 4, CL_MIN = 3, CL_MAX = 6 and 16-bit picosecond inputs. A four-cycle hold-off leaves room to show that busy stays high through several cycles and that a request raised inside that window is ignored. The 3..6 latency window puts reserved codes on both sides. Recovery times of 5 to 20 ns against periods of 1.875 to 5 ns cover the clamp to 2, exact division, round-up and overflow past 8.

// File: rtl/ddr2_mrs_issuer.sv
module ddr2_mrs_issuer #(
  parameter int TMRD   = 2,
  parameter int CL_MIN = 3,
  parameter int CL_MAX = 6,
  parameter int PS_W   = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req,
  input  logic [3:0]      cfg_bl,
  input  logic            cfg_interleave,
  input  logic [2:0]      cfg_cl,
  input  logic [PS_W-1:0] cfg_twr_ps,
  input  logic [PS_W-1:0] cfg_tck_ps,
  input  logic            cfg_slow_exit,
  input  logic [1:0]      cfg_target,
  input  logic            all_precharged,
  input  logic            cke_high,
  output logic            cs_n,
  output logic            ras_n,
  output logic            cas_n,
  output logic            we_n,
  output logic [1:0]      ba,
  output logic [12:0]     addr,
  output logic            busy,
  output logic            err
);
  localparam int CW = (TMRD > 1) ? $clog2(TMRD) : 1;
  localparam logic [CW-1:0]   HOLD_LOAD = CW'(TMRD - 1);
  localparam logic [2:0]      CL_LO     = 3'(CL_MIN);
  localparam logic [2:0]      CL_HI     = 3'(CL_MAX);
  localparam logic [PS_W:0]   ONE       = (PS_W+1)'(1);
  localparam logic [PS_W:0]   WR_MAX    = (PS_W+1)'(8);

  typedef enum logic [1:0] {S_IDLE, S_PEND, S_HOLD} state_t;
  state_t        state;
  logic [CW-1:0] hold_cnt;
  logic          cmd;

  logic [PS_W:0] wr_num, wr_den, wr_cyc;
  logic [2:0]    wr_code, bl_code;
  logic          bl_ok, cl_ok, wr_ok, cfg_ok;
  logic [12:0]   word;

  assign wr_num  = {1'b0, cfg_twr_ps} + {1'b0, cfg_tck_ps} - ONE;
  assign wr_den  = (cfg_tck_ps == '0) ? ONE : {1'b0, cfg_tck_ps};
  assign wr_cyc  = wr_num / wr_den;
  assign wr_ok   = (cfg_tck_ps != '0) && (wr_cyc <= WR_MAX);
  assign wr_code = (wr_cyc <= ONE) ? 3'd1 : 3'(wr_cyc - ONE);

  assign bl_ok   = (cfg_bl == 4'd4) || (cfg_bl == 4'd8);
  assign bl_code = (cfg_bl == 4'd8) ? 3'b011 : 3'b010;
  assign cl_ok   = (cfg_cl >= CL_LO) && (cfg_cl <= CL_HI);
  assign cfg_ok  = (cfg_target != 2'b00) || (bl_ok && cl_ok && wr_ok);

  assign word = (cfg_target != 2'b00) ? 13'd0 :
                {cfg_slow_exit, wr_code, 2'b00, cfg_cl, cfg_interleave, bl_code};

  assign cs_n  = ~cmd;
  assign ras_n = ~cmd;
  assign cas_n = ~cmd;
  assign we_n  = ~cmd;
  assign busy  = (state != S_IDLE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      hold_cnt <= '0;
      cmd      <= 1'b0;
      err      <= 1'b0;
      ba       <= 2'b00;
      addr     <= '0;
    end else begin
      cmd <= 1'b0;
      err <= 1'b0;
      case (state)
        S_IDLE: if (req) begin
          if (cfg_ok) begin
            ba    <= cfg_target;
            addr  <= word;
            state <= S_PEND;
          end else begin
            err <= 1'b1;
          end
        end
        S_PEND: if (all_precharged && cke_high) begin
          cmd      <= 1'b1;
          hold_cnt <= HOLD_LOAD;
          state    <= S_HOLD;
        end
        S_HOLD: begin
          if (hold_cnt == '0) state <= S_IDLE;
          else                hold_cnt <= hold_cnt - 1'b1;
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/ddr2_mrs_issuer_chk.sv
module ddr2_mrs_issuer_chk #(
  parameter int TMRD = 2
) (
  input logic        clk,
  input logic        rst_n,
  input logic        cs_n,
  input logic        ras_n,
  input logic        cas_n,
  input logic        we_n,
  input logic [1:0]  ba,
  input logic [12:0] addr,
  input logic        busy,
  input logic        err,
  input logic        all_precharged,
  input logic        cke_high
);
  logic cmd;
  int   gap;
  assign cmd = !cs_n && !ras_n && !cas_n && !we_n;

  always_ff @(posedge clk) begin
    if (!rst_n)          gap <= TMRD + 1;
    else if (cmd)        gap <= 1;
    else if (gap <= TMRD) gap <= gap + 1;
  end

  assert_single_cycle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    cmd |=> !cmd);
  assert_precond_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cmd |-> $past(all_precharged && cke_high));
  assert_fields_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd && ba == 2'b00) |-> (addr[8:7] == 2'b00 && addr[11:9] != 3'b000 &&
                              (addr[2:0] == 3'b010 || addr[2:0] == 3'b011)));
  assert_busy_cmd_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cmd |-> busy);
  assert_spacing_R7: assert property (@(posedge clk) disable iff (!rst_n)
    cmd |-> gap > TMRD);
  assert_reject_R8: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> (!busy && !cmd));
  assert_reject_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> !cmd);
endmodule

bind ddr2_mrs_issuer ddr2_mrs_issuer_chk #(.TMRD(TMRD)) u_chk (
  .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n),
  .we_n(we_n), .ba(ba), .addr(addr), .busy(busy), .err(err),
  .all_precharged(all_precharged), .cke_high(cke_high)
);

// File: tb/ddr2_mrs_issuer_tb.sv
module ddr2_mrs_issuer_tb;
  localparam int TMRD = 4;
  localparam int CLMN = 3;
  localparam int CLMX = 6;

  logic clk = 0, rst_n = 0, req = 0;
  logic [3:0] cfg_bl = 4;
  logic cfg_interleave = 0, cfg_slow_exit = 0;
  logic [2:0] cfg_cl = 3;
  logic [15:0] cfg_twr_ps = 15000, cfg_tck_ps = 2500;
  logic [1:0] cfg_target = 0;
  logic all_precharged = 0, cke_high = 0;
  logic cs_n, ras_n, cas_n, we_n, busy, err;
  logic [1:0] ba;
  logic [12:0] addr;
  int checks = 0, errors = 0;
  bit done = 0;

  ddr2_mrs_issuer #(.TMRD(TMRD), .CL_MIN(CLMN), .CL_MAX(CLMX), .PS_W(16)) u_dut (.*);

  always #5 clk = ~clk;

  task automatic chk(input bit ok, input string r, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", r, act, exp);
    end
  endtask

  function automatic int wr_cycles(int twr, int tck);
    return (twr + tck - 1) / tck;
  endfunction

  function automatic bit exp_ok(int bl, int cl, int twr, int tck, int tgt);
    if (tgt != 0) return 1;
    if (bl != 4 && bl != 8) return 0;
    if (cl < CLMN || cl > CLMX) return 0;
    if (tck == 0) return 0;
    return wr_cycles(twr, tck) <= 8;
  endfunction

  function automatic int exp_word(int bl, bit il, int cl, int twr, int tck, bit slow, int tgt);
    int wr;
    if (tgt != 0) return 0;
    wr = wr_cycles(twr, tck);
    if (wr < 2) wr = 2;
    return (int'(slow) << 12) | ((wr - 1) << 9) | (cl << 4) | (int'(il) << 3) | ((bl == 8) ? 3 : 2);
  endfunction

  function automatic int strobes();
    return {28'd0, cs_n, ras_n, cas_n, we_n};
  endfunction

  task automatic run_one(input int bl, input bit il, input int cl, input int twr, input int tck,
                         input bit slow, input int tgt, input int stall, input bit probe);
    bit ok;
    int w;
    ok = exp_ok(bl, cl, twr, tck, tgt);
    w  = exp_word(bl, il, cl, twr, tck, slow, tgt);
    @(negedge clk);
    cfg_bl = 4'(bl); cfg_interleave = il; cfg_cl = 3'(cl);
    cfg_twr_ps = 16'(twr); cfg_tck_ps = 16'(tck); cfg_slow_exit = slow; cfg_target = 2'(tgt);
    all_precharged = (stall == 0); cke_high = (stall == 0);
    req = 1;
    @(negedge clk);
    req = 0;
    if (!ok) begin
      chk(err == 1, "R8 err pulse", int'(err), 1);
      chk(busy == 0, "R8 busy low", int'(busy), 0);
      repeat (3) begin
        @(negedge clk);
        chk(strobes() == 15, "R8 no command", strobes(), 15);
      end
      return;
    end
    chk(busy == 1, "R6 busy at accept", int'(busy), 1);
    chk(err == 0, "R8 no err", int'(err), 0);
    for (int i = 0; i < stall; i++) begin
      all_precharged = $urandom_range(0, 1);
      cke_high = !all_precharged ? $urandom_range(0, 1) : 1'b0;
      @(negedge clk);
      chk(strobes() == 15, "R2 held pending", strobes(), 15);
    end
    all_precharged = 1; cke_high = 1;
    @(negedge clk);
    chk(strobes() == 0, "R1 R2 command", strobes(), 0);
    chk(ba == 2'(tgt), "R4 bank select", int'(ba), tgt);
    chk(addr == 13'(w), "R3 R5 word", int'(addr), w);
    if (probe) req = 1;
    for (int j = 1; j < TMRD; j++) begin
      @(negedge clk);
      req = 0;
      chk(strobes() == 15, "R1 R7 single cycle", strobes(), 15);
      chk(busy == 1, "R6 busy hold", int'(busy), 1);
    end
    @(negedge clk);
    chk(busy == 0, "R6 busy release", int'(busy), 0);
    if (probe) repeat (3) begin
      @(negedge clk);
      chk(strobes() == 15 && busy == 0, "R9 busy request ignored", strobes(), 15);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(strobes() == 15, "R1 reset strobes", strobes(), 15);
    chk(busy == 0 && err == 0, "R6 reset busy", int'(busy), 0);

    run_one(4, 0, 3, 15000, 2500, 0, 0, 0, 0);   // exact ratio, code 5
    run_one(8, 1, 6, 15001, 2500, 1, 0, 2, 0);   // round-up to 7
    run_one(4, 1, 5, 1000, 2500, 0, 0, 1, 0);    // clamp to 2, R5
    run_one(8, 0, 4, 20000, 2500, 0, 0, 0, 1);   // count 8, R9 probe
    run_one(8, 0, 4, 20001, 2500, 0, 0, 0, 0);   // count 9, R8 reject
    run_one(4, 0, 4, 15000, 0, 0, 0, 0, 0);      // zero period, R8
    run_one(2, 0, 4, 15000, 2500, 0, 0, 0, 0);   // burst 2, R8
    run_one(4, 0, 2, 15000, 2500, 0, 0, 0, 0);   // latency 2, R8
    run_one(4, 0, 7, 15000, 2500, 0, 0, 0, 0);   // latency 7, R8
    for (int t = 1; t < 4; t++) run_one(2, 0, 0, 0, 0, 0, t, 1, 0); // R4 extended
    run_one(8, 1, 3, 7500, 1875, 1, 0, 5, 1);

    for (int n = 0; n < 80; n++) begin
      int bl, cl;
      bl = ($urandom_range(0, 3) == 0) ? $urandom_range(0, 15) : (($urandom_range(0, 1) != 0) ? 8 : 4);
      cl = $urandom_range(0, 7);
      run_one(bl, 1'($urandom_range(0, 1)), cl, $urandom_range(5000, 20000),
              $urandom_range(1875, 5000), 1'($urandom_range(0, 1)),
              ($urandom_range(0, 4) == 0) ? $urandom_range(1, 3) : 0,
              $urandom_range(0, 3), 1'($urandom_range(0, 1)));
    end

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule